// File: doc/BRIEF.md
# None-Some-Many LFSR Signature Tester

This block grades a stretch of fabric flip-flops by how badly it is broken. The flops are first wired as one long linear feedback shift register. The register is loaded from a seed, clocked for a fixed number of steps, and its final contents are compared with a golden signature. If the signature matches, the result is "none". If it does not match, only the segment-head links are rewired. The chain becomes several equal, independent shorter registers. Each of them is reloaded from its slice of the seed, clocked for the same number of steps, and compared with its own golden slice. When fewer than half of the segments disagree, the result is "some". Otherwise it is "many".

A match is only evidence, not proof. A faulty chain can still alias onto the golden value. Faults are modelled at the ports by a per-bit stuck-at mask and a stuck value. The golden signatures are worked out elsewhere and are supplied as inputs.

The control is one state machine with the states IDLE, SEED_FULL, RUN_FULL, CHECK_FULL, SEED_SPLIT, RUN_SPLIT, CHECK_SPLIT and DONE. Its transitions are:
- IDLE to SEED_FULL when `start` is high.
- SEED_FULL to RUN_FULL.
- RUN_FULL to CHECK_FULL after `RUN_CYCLES` steps.
- CHECK_FULL to DONE on a match, or to SEED_SPLIT on a mismatch.
- SEED_SPLIT to RUN_SPLIT.
- RUN_SPLIT to CHECK_SPLIT after `RUN_CYCLES` steps.
- CHECK_SPLIT to DONE.
- DONE to IDLE.

Top module: `nsm_sig_tester`

## Requirements
- R1: After reset, `res_valid` is 0 and `res_class` is 0.
- R2: When the full-chain signature equals `full_gold`, the class is none (0). `res_valid` rises after exactly RUN_CYCLES+3 rising edges, counting the edge that samples `start`. No split run takes place.
- R3: When the full-chain signature differs from `full_gold`, a split run follows. `res_valid` rises after exactly 2*RUN_CYCLES+5 rising edges from the edge that samples `start`.
- R4: After a split run, if twice the number of mismatching segments is less than NSEG, the class is some (1).
- R5: After a split run, if twice the number of mismatching segments is NSEG or more, the class is many (2).
- R6: The class code is 0 for none, 1 for some and 2 for many. The code 3 never appears with `res_valid`.
- R7: `res_valid` is high for exactly one cycle per run.
- R8: Let L = WIDTH/NSEG. In full mode, on each step bit 0 takes bit WIDTH-1 XOR bit FULL_TAP, and every other bit i takes bit i-1. In split mode, each segment head k*L instead takes bit k*L+L-1 XOR bit k*L+SEG_TAP, and the other bits still shift. A signature is the chain value after exactly RUN_CYCLES steps from the seed.
- R9: Every bit whose `stuck_mask` bit is 1 reads as its `stuck_val` bit at all times, including right after seeding. Both the feedback and the signature see that stuck value.
- R10: A `start` that arrives while a run is in progress has no effect. The run keeps its timing and produces a single result.
- R11: Segment k is compared with `seg_gold` bits k*L+L-1 down to k*L. A full mismatch followed by all segments matching gives some (1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when the block is idle |
| seed | input | WIDTH | Initial chain value, also sliced for the segments |
| full_gold | input | WIDTH | Golden signature of the full chain |
| seg_gold | input | WIDTH | Golden signatures of the segments, concatenated |
| stuck_mask | input | WIDTH | 1 marks a flop as stuck |
| stuck_val | input | WIDTH | Stuck value for each marked flop |
| res_valid | output | 1 | One-cycle pulse when the class is ready |
| res_class | output | 2 | 0 none, 1 some, 2 many |

## Verification
The assertions check several rules on every cycle:
- the decision taken in CHECK_FULL;
- the mapping from the segment mismatch count to some or many;
- the one-cycle width of the result pulse;
- the absence of code 3;
- the bound on the step counter;
- that a `start` during a run is ignored.

The directed scenarios are needed for everything that depends on data:
- that the feedback taps and the segment rewiring produce the right signatures;
- that stuck bits change the outcome as predicted;
- the exact latencies of the none path and the split path.

The bench checks these against its own bit-level model of the chain.

// File: rtl/nsm_pkg.sv
package nsm_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_SOME = 2'd1,
        CLS_MANY = 2'd2
    } cls_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEED_FULL,
        ST_RUN_FULL,
        ST_CHECK_FULL,
        ST_SEED_SPLIT,
        ST_RUN_SPLIT,
        ST_CHECK_SPLIT,
        ST_DONE
    } st_t;

endpackage

// File: rtl/nsm_lfsr_chain.sv
module nsm_lfsr_chain #(
    parameter int WIDTH    = 96,
    parameter int NSEG     = 4,
    parameter int FULL_TAP = 53,
    parameter int SEG_TAP  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             split_mode,
    input  logic [WIDTH-1:0] seed,
    input  logic [WIDTH-1:0] stuck_mask,
    input  logic [WIDTH-1:0] stuck_val,
    output logic [WIDTH-1:0] sig
);
    localparam int SEG_L = WIDTH / NSEG;

    logic [WIDTH-1:0] q;
    logic [WIDTH-1:0] eff;
    logic [WIDTH-1:0] nxt;

    // stuck flops override what is stored
    assign eff = (q & ~stuck_mask) | (stuck_val & stuck_mask);
    assign sig = eff;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        if (i % SEG_L == 0) begin : g_head
            logic fb_seg;
            assign fb_seg = eff[i + SEG_L - 1] ^ eff[i + SEG_TAP];
            if (i == 0) begin : g_first
                assign nxt[i] = split_mode ? fb_seg : (eff[WIDTH-1] ^ eff[FULL_TAP]);
            end else begin : g_mid
                assign nxt[i] = split_mode ? fb_seg : eff[i-1];
            end
        end else begin : g_body
            assign nxt[i] = eff[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= seed;
        else if (step) q <= nxt;
    end
endmodule

// File: rtl/nsm_sig_compare.sv
module nsm_sig_compare #(
    parameter int WIDTH = 96,
    parameter int NSEG  = 4,
    parameter int MC_W  = 3
) (
    input  logic [WIDTH-1:0] sig,
    input  logic [WIDTH-1:0] full_gold,
    input  logic [WIDTH-1:0] seg_gold,
    output logic             full_miss,
    output logic [MC_W-1:0]  miss_cnt
);
    localparam int SEG_L = WIDTH / NSEG;

    logic [NSEG-1:0] seg_miss;

    assign full_miss = (sig != full_gold);

    for (genvar k = 0; k < NSEG; k++) begin : g_seg
        assign seg_miss[k] = (sig[k*SEG_L +: SEG_L] != seg_gold[k*SEG_L +: SEG_L]);
    end

    always_comb begin
        miss_cnt = '0;
        for (int k = 0; k < NSEG; k++) begin
            miss_cnt = miss_cnt + MC_W'(seg_miss[k]);
        end
    end
endmodule

// File: rtl/nsm_sig_tester.sv
module nsm_sig_tester
    import nsm_pkg::*;
#(
    parameter int WIDTH      = 96,
    parameter int NSEG       = 4,
    parameter int RUN_CYCLES = 64,
    parameter int FULL_TAP   = 53,
    parameter int SEG_TAP    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] seed,
    input  logic [WIDTH-1:0] full_gold,
    input  logic [WIDTH-1:0] seg_gold,
    input  logic [WIDTH-1:0] stuck_mask,
    input  logic [WIDTH-1:0] stuck_val,
    output logic             res_valid,
    output logic [1:0]       res_class
);
    localparam int CNT_W = $clog2(RUN_CYCLES + 1);
    localparam int MC_W  = $clog2(NSEG + 1);

    st_t             state, state_nx;
    logic [CNT_W-1:0] cnt;
    logic            full_miss;
    logic [MC_W-1:0] miss_cnt;
    logic [WIDTH-1:0] sig;
    logic            load, step, split_mode, run_last;
    cls_t            cls_q;

    assign load       = (state == ST_SEED_FULL) || (state == ST_SEED_SPLIT);
    assign step       = (state == ST_RUN_FULL)  || (state == ST_RUN_SPLIT);
    assign split_mode = (state == ST_SEED_SPLIT) || (state == ST_RUN_SPLIT)
                     || (state == ST_CHECK_SPLIT);
    assign run_last   = (cnt == CNT_W'(RUN_CYCLES - 1));

    nsm_lfsr_chain #(
        .WIDTH(WIDTH), .NSEG(NSEG), .FULL_TAP(FULL_TAP), .SEG_TAP(SEG_TAP)
    ) u_chain (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .split_mode(split_mode), .seed(seed),
        .stuck_mask(stuck_mask), .stuck_val(stuck_val), .sig(sig)
    );

    nsm_sig_compare #(
        .WIDTH(WIDTH), .NSEG(NSEG), .MC_W(MC_W)
    ) u_cmp (
        .sig(sig), .full_gold(full_gold), .seg_gold(seg_gold),
        .full_miss(full_miss), .miss_cnt(miss_cnt)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:        if (start) state_nx = ST_SEED_FULL;
            ST_SEED_FULL:   state_nx = ST_RUN_FULL;
            ST_RUN_FULL:    if (run_last) state_nx = ST_CHECK_FULL;
            ST_CHECK_FULL:  state_nx = full_miss ? ST_SEED_SPLIT : ST_DONE;
            ST_SEED_SPLIT:  state_nx = ST_RUN_SPLIT;
            ST_RUN_SPLIT:   if (run_last) state_nx = ST_CHECK_SPLIT;
            ST_CHECK_SPLIT: state_nx = ST_DONE;
            ST_DONE:        state_nx = ST_IDLE;
            default:        state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // step counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt <= '0;
        else if (step) cnt <= run_last ? '0 : cnt + 1'b1;
        else           cnt <= '0;
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cls_q <= CLS_NONE;
        end else begin
            unique case (state)
                ST_CHECK_FULL:  if (!full_miss) cls_q <= CLS_NONE;
                ST_CHECK_SPLIT: cls_q <= ((2 * int'(miss_cnt)) < NSEG) ? CLS_SOME : CLS_MANY;
                default:        cls_q <= cls_q;
            endcase
        end
    end

    assign res_valid = (state == ST_DONE);
    assign res_class = cls_q;
endmodule

// File: rtl/nsm_sig_tester_chk.sv
module nsm_sig_tester_chk
    import nsm_pkg::*;
#(
    parameter int NSEG       = 4,
    parameter int RUN_CYCLES = 64,
    parameter int CNT_W      = 7,
    parameter int MC_W       = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input st_t              state,
    input logic [CNT_W-1:0] cnt,
    input logic             full_miss,
    input logic [MC_W-1:0]  miss_cnt,
    input logic             res_valid,
    input logic [1:0]       res_class
);
    p_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    p_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_class != 2'd3));

    p_none_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK_FULL && !full_miss) |=> (res_valid && res_class == CLS_NONE));

    p_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK_FULL && full_miss) |=> (state == ST_SEED_SPLIT));

    p_some_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK_SPLIT && (2 * int'(miss_cnt)) < NSEG) |=> (res_class == CLS_SOME));

    p_many_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK_SPLIT && (2 * int'(miss_cnt)) >= NSEG) |=> (res_class == CLS_MANY));

    p_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN_FULL || state == ST_RUN_SPLIT) |-> (int'(cnt) < RUN_CYCLES));

    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN_FULL && start) |=> (state == ST_RUN_FULL || state == ST_CHECK_FULL));
endmodule

bind nsm_sig_tester nsm_sig_tester_chk #(
    .NSEG(NSEG), .RUN_CYCLES(RUN_CYCLES), .CNT_W(CNT_W), .MC_W(MC_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state), .cnt(cnt),
    .full_miss(full_miss), .miss_cnt(miss_cnt),
    .res_valid(res_valid), .res_class(res_class)
);

// File: tb/tb_nsm_sig_tester.sv
module tb_nsm_sig_tester;
    localparam int W        = 96;
    localparam int NSEG     = 4;
    localparam int L        = W / NSEG;
    localparam int RUN      = 64;
    localparam int FULL_TAP = 53;
    localparam int SEG_TAP  = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] seed = '0, full_gold = '0, seg_gold = '0;
    logic [W-1:0] stuck_mask = '0, stuck_val = '0;
    logic         res_valid;
    logic [1:0]   res_class;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;  // 250 MHz

    nsm_sig_tester #(
        .WIDTH(W), .NSEG(NSEG), .RUN_CYCLES(RUN), .FULL_TAP(FULL_TAP), .SEG_TAP(SEG_TAP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
        .full_gold(full_gold), .seg_gold(seg_gold),
        .stuck_mask(stuck_mask), .stuck_val(stuck_val),
        .res_valid(res_valid), .res_class(res_class)
    );

    // chain model built from R8 and R9
    function automatic logic [W-1:0] model(input logic [W-1:0] s, input logic [W-1:0] m,
                                           input logic [W-1:0] v, input bit split);
        logic [W-1:0] q, e, n;
        q = s;
        for (int c = 0; c < RUN; c++) begin
            e = (q & ~m) | (v & m);
            n = e << 1;
            if (!split) n[0] = e[W-1] ^ e[FULL_TAP];
            else for (int k = 0; k < NSEG; k++) n[k*L] = e[k*L+L-1] ^ e[k*L+SEG_TAP];
            q = n;
        end
        return (q & ~m) | (v & m);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one run: drives start, checks class, latency and pulse width
    task automatic run_case(input string name, input logic [W-1:0] m, input logic [W-1:0] v,
                            input bit bad_full, input bit restart, input string creq);
        logic [W-1:0] fs, ss;
        int exp_cls, exp_lat, nmiss, lat;
        full_gold  = model(seed, '0, '0, 1'b0) ^ (bad_full ? {{(W-1){1'b0}}, 1'b1} : '0);
        seg_gold   = model(seed, '0, '0, 1'b1);
        stuck_mask = m;
        stuck_val  = v;
        fs = model(seed, m, v, 1'b0);
        if (fs == full_gold) begin
            exp_cls = 0; exp_lat = RUN + 3;
        end else begin
            ss = model(seed, m, v, 1'b1);
            nmiss = 0;
            for (int k = 0; k < NSEG; k++)
                if (ss[k*L +: L] != seg_gold[k*L +: L]) nmiss++;
            exp_cls = (2 * nmiss < NSEG) ? 1 : 2;
            exp_lat = 2 * RUN + 5;
        end
        @(negedge clk);
        start = 1'b1;
        lat = 0;
        while (lat < 1000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = (restart && lat == 10) ? 1'b1 : 1'b0;
            if (res_valid) break;
        end
        start = 1'b0;
        $display("case %s", name);
        check(creq, int'(res_class), exp_cls);
        check(exp_lat == RUN + 3 ? "R2 latency" : "R3 latency", lat, exp_lat);
        @(negedge clk);
        check("R7 pulse", int'(res_valid), 0);
        repeat (20) begin
            @(negedge clk);
            if (res_valid) check("R10 extra result", 1, 0);
        end
    endtask

    task automatic t_reset();
        check("R1 valid", int'(res_valid), 0);
        check("R1 class", int'(res_class), 0);
    endtask

    task automatic t_clean();
        run_case("clean", '0, '0, 1'b0, 1'b0, "R2 R8 class none");
    endtask

    task automatic t_one_seg();
        logic [W-1:0] m = '0;
        m[2*L + 5] = 1'b1;
        run_case("one segment stuck", m, ~seed, 1'b0, 1'b0, "R4 R9 class some");
    endtask

    task automatic t_two_seg();
        logic [W-1:0] m = '0;
        m[3] = 1'b1; m[L + 7] = 1'b1;
        run_case("two segments stuck", m, ~seed, 1'b0, 1'b0, "R5 R9 class many");
    endtask

    task automatic t_all_seg();
        logic [W-1:0] m = '0;
        for (int k = 0; k < NSEG; k++) m[k*L + 2] = 1'b1;
        run_case("all segments stuck", m, '0, 1'b0, 1'b0, "R5 R6 class many");
    endtask

    task automatic t_whole_seg_stuck();
        logic [W-1:0] m = '0;
        m[L-1:0] = '1;
        run_case("segment zero frozen", m, {W{1'b1}} ^ seed, 1'b0, 1'b0, "R9 class");
    endtask

    task automatic t_gold_only();
        run_case("full golden off", '0, '0, 1'b1, 1'b0, "R11 R3 class some");
    endtask

    task automatic t_restart();
        run_case("start during run", '0, '0, 1'b0, 1'b1, "R10 class none");
    endtask

    initial begin
        seed = {32'hC0FF_EE11, 32'h1234_5678, 32'h9ABC_DEF1};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_clean();
        t_one_seg();
        t_two_seg();
        t_all_seg();
        t_whole_seg_stuck();
        t_gold_only();
        t_restart();
        seed = {32'h0000_0001, 32'hFFFF_0000, 32'h5555_AAAA};
        t_clean();
        t_one_seg();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule